// File: doc/BRIEF.md
# Two-Read One-Write Register File on a Phase-Split Array

This block is a small processor register file that delivers two operand reads and one result write in every external cycle, while its storage array offers only one access per step: either a pair of reads or a single write. The block runs on a clock at twice the external rate. An internal phase bit divides each external cycle into a read step followed by a write step. The read step fetches both operands into output registers. The write step then commits the result.

A pipelined core presents both source addresses and the destination write for one external cycle. It picks up the operands on the two data outputs once the read step has ended. The `wr_phase` output shows which step the array is in, so the surrounding logic can align its external cycle with the block. A read and a write to the same entry in the same cycle return the contents from before the write. Entry zero always reads as zero.

Top module: `rf2r1w`

## Requirements
- R1: While `rst` is high at a rising edge of `clk2x`, the block goes to the read step (`wr_phase` = 0) and clears both read outputs to zero.
- R2: After reset, `wr_phase` toggles on every rising edge of `clk2x`: 0 (read step), then 1 (write step), and so on. One external cycle is one read step followed by one write step.
- R3: At the rising edge that ends a read step, `rd_data_a` and `rd_data_b` load the contents of the entries at `rd_addr_a` and `rd_addr_b`.
- R4: The read outputs do not change at the edge that ends a write step, so each value holds for a whole external cycle.
- R5: At the edge that ends a write step, if `wr_en` is 1 and `wr_addr` is non-zero, `wr_data` is stored at `wr_addr` and is returned by later reads of that entry.
- R6: A read of an entry that is written in the same external cycle returns the contents from before the write. The new value is returned from the next cycle onward.
- R7: Entry 0 always reads as zero, and writes to entry 0 have no effect.
- R8: When `wr_en` is 0 during a write step, no entry changes.
- R9: The two read ports work independently. Both may address the same entry, and each returns that entry's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the external cycle rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Entry selected for read port A |
| rd_addr_b | input | 5 | Entry selected for read port B |
| rd_data_a | output | 32 | Registered read result of port A |
| rd_data_b | output | 32 | Registered read result of port B |
| wr_en | input | 1 | Write request for this external cycle |
| wr_addr | input | 5 | Entry to write |
| wr_data | input | 32 | Value to write |
| wr_phase | output | 1 | 0 during the read step, 1 during the write step |

## Verification
Read results appear one `clk2x` edge after the read step begins. They are sampled at the falling edge that follows, and sampled again after the write-step edge to confirm they have held. A write takes effect at the second edge of its external cycle. Its value is therefore expected only from the read step of the next cycle, so the bench checks that the old value is returned in the writing cycle and the new value in the cycle after it. Every stimulus is applied at a falling edge while `wr_phase` is 0 and is held across both edges of the cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } phase_e;
endpackage

// File: rtl/rf_phase_gen.sv
module rf_phase_gen
  import rf_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_READ;
    else     phase <= (phase == PH_READ) ? PH_WRITE : PH_READ;
  end
endmodule

// File: rtl/rf_wr_qual.sv
module rf_wr_qual
  import rf_pkg::*;
#(
  parameter int AW = 5
) (
  input  phase_e        phase,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic          commit
);
  // Writes only in the write step, and never to the hard-wired zero entry.
  always_comb commit = (phase == PH_WRITE) && req && (addr != '0);
endmodule

// File: rtl/rf_array.sv
module rf_array #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_step,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][DW-1:0]   rd_q,
  input  logic                     wr_commit,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_commit) mem[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)
        rd_q[p] <= '0;
      else if (rd_step)
        rd_q[p] <= (rd_addr[p] == '0) ? '0 : mem[rd_addr[p]];
    end
  end
endmodule

// File: rtl/rf2r1w.sv
module rf2r1w
  import rf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk2x,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_phase
);
  localparam int NRD = 2;

  phase_e                   phase;
  logic                     commit;
  logic [NRD-1:0][AW-1:0]   ra;
  logic [NRD-1:0][DW-1:0]   rq;

  rf_phase_gen u_phase (
    .clk   (clk2x),
    .rst   (rst),
    .phase (phase)
  );

  rf_wr_qual #(.AW(AW)) u_wq (
    .phase  (phase),
    .req    (wr_en),
    .addr   (wr_addr),
    .commit (commit)
  );

  always_comb begin
    ra[0] = rd_addr_a;
    ra[1] = rd_addr_b;
  end

  rf_array #(.DW(DW), .DEPTH(DEPTH), .NRD(NRD)) u_arr (
    .clk       (clk2x),
    .rst       (rst),
    .rd_step   (phase == PH_READ),
    .rd_addr   (ra),
    .rd_q      (rq),
    .wr_commit (commit),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  assign rd_data_a = rq[0];
  assign rd_data_b = rq[1];
  assign wr_phase  = (phase == PH_WRITE);
endmodule

// File: rtl/rf2r1w_chk.sv
module rf2r1w_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk2x,
  input logic          rst,
  input logic [AW-1:0] rd_addr_a,
  input logic [AW-1:0] rd_addr_b,
  input logic [DW-1:0] rd_data_a,
  input logic [DW-1:0] rd_data_b,
  input logic          wr_phase
);
  // R1
  reset_state_chk: assert property (@(posedge clk2x) disable iff (rst)
    $past(rst) |-> (!wr_phase && rd_data_a == '0 && rd_data_b == '0));

  // R2
  read_to_write_chk: assert property (@(posedge clk2x) disable iff (rst)
    !wr_phase |=> wr_phase);

  // R2
  write_to_read_chk: assert property (@(posedge clk2x) disable iff (rst)
    wr_phase |=> !wr_phase);

  // R4
  hold_in_write_chk: assert property (@(posedge clk2x) disable iff (rst)
    wr_phase |=> ($stable(rd_data_a) && $stable(rd_data_b)));

  // R7
  zero_port_a_chk: assert property (@(posedge clk2x) disable iff (rst)
    (!wr_phase && rd_addr_a == '0) |=> rd_data_a == '0);

  // R7
  zero_port_b_chk: assert property (@(posedge clk2x) disable iff (rst)
    (!wr_phase && rd_addr_b == '0) |=> rd_data_b == '0);
endmodule

bind rf2r1w rf2r1w_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk2x     (clk2x),
  .rst       (rst),
  .rd_addr_a (rd_addr_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_a (rd_data_a),
  .rd_data_b (rd_data_b),
  .wr_phase  (wr_phase)
);

// File: tb/sim_rf2r1w.sv
`timescale 1ns/1ps
module sim_rf2r1w;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int N  = 32;

  logic          clk2x = 1'b0;
  logic          rst   = 1'b1;
  logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data_a, rd_data_b;
  logic          wr_phase;

  logic [DW-1:0] model [N];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk2x = ~clk2x;

  rf2r1w u0 (
    .clk2x(clk2x), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_phase(wr_phase)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i, input logic [DW-1:0] salt);
    return (32'h9E3779B9 * (i + 1)) ^ salt;
  endfunction

  // One external cycle: inputs driven while wr_phase is 0, held over both edges.
  task automatic ext_cycle(input logic [AW-1:0] a, input logic [AW-1:0] b,
                           input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                           output logic [DW-1:0] qa, output logic [DW-1:0] qb);
    rd_addr_a = a; rd_addr_b = b; wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk2x); @(negedge clk2x);
    qa = rd_data_a; qb = rd_data_b;
    chk("R2 write step after read step", {31'b0, wr_phase}, 32'd1);
    @(posedge clk2x); @(negedge clk2x);
    chk("R4 port A held", rd_data_a, qa);
    chk("R4 port B held", rd_data_b, qb);
    chk("R2 read step after write step", {31'b0, wr_phase}, 32'd0);
    if (we && wa != 0) model[wa] = wd;
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk2x);
    @(negedge clk2x);
    rst = 1'b0;
    chk("R1 phase after reset", {31'b0, wr_phase}, 32'd0);
    chk("R1 port A after reset", rd_data_a, '0);
    chk("R1 port B after reset", rd_data_b, '0);
  endtask

  task automatic t_fill_and_read;
    logic [DW-1:0] qa, qb;
    for (int i = 1; i < N; i++) ext_cycle('0, '0, 1'b1, AW'(i), pat(i, 32'hA5C3_0F1E), qa, qb);
    for (int i = 1; i < N; i++) begin
      ext_cycle(AW'(i), AW'(N - i), 1'b0, '0, '0, qa, qb);
      chk("R5/R3 port A read", qa, model[i]);
      chk("R3 port B read", qb, model[N - i]);
    end
  endtask

  task automatic t_same_cycle;
    logic [DW-1:0] qa, qb, old;
    old = model[5];
    ext_cycle(5'd5, 5'd6, 1'b1, 5'd5, 32'hDEAD_BEEF, qa, qb);
    chk("R6 old value in writing cycle", qa, old);
    ext_cycle(5'd6, 5'd5, 1'b0, '0, '0, qa, qb);
    chk("R6 new value next cycle", qb, 32'hDEAD_BEEF);
    chk("R3 untouched neighbour", qa, model[6]);
  endtask

  task automatic t_zero_entry;
    logic [DW-1:0] qa, qb;
    ext_cycle('0, '0, 1'b1, '0, 32'hFFFF_FFFF, qa, qb);
    ext_cycle('0, '0, 1'b0, '0, '0, qa, qb);
    chk("R7 port A zero entry", qa, '0);
    chk("R7 port B zero entry", qb, '0);
  endtask

  task automatic t_no_enable;
    logic [DW-1:0] qa, qb;
    ext_cycle('0, '0, 1'b0, 5'd7, 32'h1234_5678, qa, qb);
    ext_cycle(5'd7, 5'd3, 1'b0, '0, '0, qa, qb);
    chk("R8 disabled write left entry", qa, model[7]);
    chk("R8 other entry", qb, model[3]);
  endtask

  task automatic t_same_addr;
    logic [DW-1:0] qa, qb;
    ext_cycle(5'd31, 5'd31, 1'b1, 5'd12, 32'h0BAD_F00D, qa, qb);
    chk("R9 port A same entry", qa, model[31]);
    chk("R9 port B same entry", qb, model[31]);
    ext_cycle(5'd12, 5'd12, 1'b0, '0, '0, qa, qb);
    chk("R9/R5 both ports see write", qa, 32'h0BAD_F00D);
    chk("R9/R5 both ports see write B", qb, 32'h0BAD_F00D);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    t_reset();
    t_fill_and_read();
    t_same_cycle();
    t_zero_entry();
    t_no_enable();
    t_same_addr();
    t_reset();
    done = 1;
    finish_run();
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule